// File: doc/BRIEF.md
# Address Stepper Unit

The address stepper produces a sequence of data addresses for a data-driven sequencer. Its loop counter counts data items, not instructions. A parallel configuration load supplies six values: the first address, a step vector, a direction, a lower bound, an upper bound and the number of steps. After the load, each cycle with the enable high moves the address by the step vector. The move is an addition or a subtraction, as the direction selects. With this, one unit can produce linear, strided and descending scans.

The unit stops itself in one of two ways. The first is when the number of accepted steps equals the programmed count. The second is when a step would leave the window set by the two bounds; this is called an escape. The window check is inclusive. Wraparound in the 16-bit address arithmetic is caught by the window check. A stopped unit ignores the enable until the next configuration load.

The same unit can serve as a moving lower bound, a moving upper bound or the main address generator when several copies are composed. That composition is outside this block.

A state machine in the control part holds the unit's condition:
- `ST_IDLE` is the state after reset.
- `ST_RUN` means the unit is stepping.
- `ST_END` means the step count was reached.
- `ST_ESC` means the window was left.

Transitions:
- A load moves the unit from any state to `ST_RUN`, or to `ST_END` when the loaded count is zero.
- `ST_RUN` goes to `ST_ESC` on an enabled step whose result is outside the window.
- `ST_RUN` goes to `ST_END` on the enabled step that reaches the count.
- Otherwise every state holds.

Top module: `addr_stepper`

## Requirements
- R1: After reset, `addr` is 0 and `step_valid`, `done` and `escape` are 0. `step_en` has no effect until the first `init`.
- R2: A cycle with `init` high loads the configuration and clears the step count. From the next cycle `addr` equals `cfg_start` and `escape` is 0. `init` wins over `step_en` in the same cycle.
- R3: With `cfg_down` = 0, an accepted step sets `addr` to `addr + step` modulo 2^16. `step_valid` is high for exactly the one cycle after the step.
- R4: With `cfg_down` = 1, an accepted step sets `addr` to `addr - step` modulo 2^16.
- R5: A running cycle with `step_en` low leaves `addr` unchanged, and `step_valid` is 0 in the following cycle.
- R6: With `cfg_max` = N > 0, `done` rises together with the `step_valid` of the N-th accepted step. The address of that step is presented on `addr`.
- R7: With `cfg_max` = 0, `done` is 1 from the cycle after `init`, and no step is taken.
- R8: The window is inclusive. A result equal to `cfg_base` or to `cfg_limit` is accepted. Every presented stepped address lies within [base, limit].
- R9: A step whose result, after wraparound, is below the base or above the limit is rejected. `escape` goes to 1, `addr` keeps its previous value and `step_valid` stays 0.
- R10: When the step that reaches the count also leaves the window, `escape` is set and `done` stays 0. The two flags are never high together.
- R11: Once `done` or `escape` is set, `step_en` is ignored. `addr` and the flag hold until the next `init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Load configuration and restart the sequence |
| cfg_start | input | AW | First address of the sequence |
| cfg_step | input | AW | Step vector magnitude |
| cfg_down | input | 1 | 1 = subtract the step, 0 = add it |
| cfg_base | input | AW | Inclusive lower bound of the window |
| cfg_limit | input | AW | Inclusive upper bound of the window |
| cfg_max | input | CW | Number of steps; 0 ends the sequence at once |
| step_en | input | 1 | Take one step this cycle |
| addr | output | AW | Current address |
| step_valid | output | 1 | A step was accepted in the previous cycle |
| done | output | 1 | Step count reached (sticky until `init`) |
| escape | output | 1 | Window left (sticky until `init`) |

## Verification
The assertions assume that the configuration inputs matter only in a cycle with `init` high. They check stepped addresses against the loaded copies of step, direction and bounds, never against the live configuration ports. The bench keeps to this by changing the configuration only together with an `init` pulse. Each sweep starts from a fresh load, so no property ever sees a step taken from a stale configuration. The sweeps use a small window and short counts so that every end, escape and wrap case is reached within a few steps.

// File: rtl/addr_stepper_pkg.sv
package addr_stepper_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_END  = 2'd2,
        ST_ESC  = 2'd3
    } stp_state_e;

endpackage

// File: rtl/asu_cfg_reg.sv
module asu_cfg_reg #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] in_step,
    input  logic          in_down,
    input  logic [AW-1:0] in_base,
    input  logic [AW-1:0] in_limit,
    input  logic [CW-1:0] in_max,
    output logic [AW-1:0] step_q,
    output logic          down_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic [CW-1:0] max_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q  <= '0;
            down_q  <= 1'b0;
            base_q  <= '0;
            limit_q <= '0;
            max_q   <= '0;
        end else if (load) begin
            step_q  <= in_step;
            down_q  <= in_down;
            base_q  <= in_base;
            limit_q <= in_limit;
            max_q   <= in_max;
        end
    end

endmodule

// File: rtl/asu_addr_path.sv
module asu_addr_path #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start,
    input  logic          advance,
    input  logic [AW-1:0] step,
    input  logic          down,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] addr_q,
    output logic          nxt_in_win
);

    logic [AW-1:0] nxt_addr;
    logic          above_base;
    logic          below_limit;

    // Modulo 2^AW: the carry or borrow is dropped on purpose.
    always_comb begin
        if (down) begin
            nxt_addr = addr_q - step;
        end else begin
            nxt_addr = addr_q + step;
        end
    end

    // Both bounds inclusive.
    always_comb begin
        above_base  = (nxt_addr >= base);
        below_limit = (nxt_addr <= limit);
        nxt_in_win  = above_base && below_limit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= start;
        end else if (advance) begin
            addr_q <= nxt_addr;
        end
    end

endmodule

// File: rtl/asu_step_count.sv
module asu_step_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [CW-1:0] max_q,
    output logic          last_step
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc   = cnt_q + 1'b1;
        last_step = (cnt_inc == max_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/asu_fsm.sv
module asu_fsm
    import addr_stepper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic max_zero,
    input  logic step_en,
    input  logic nxt_in_win,
    input  logic last_step,
    output logic advance,
    output logic step_valid,
    output logic done,
    output logic escape
);

    stp_state_e state_q;
    stp_state_e state_d;
    logic       try_step;
    logic       esc_hit;
    logic       end_hit;

    always_comb begin
        try_step = (state_q == ST_RUN) && step_en && !init;
        advance  = try_step && nxt_in_win;
        esc_hit  = try_step && !nxt_in_win;
        end_hit  = advance && last_step;
    end

    always_comb begin
        state_d = state_q;
        if (init) begin
            state_d = max_zero ? ST_END : ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (esc_hit) begin
                        state_d = ST_ESC;
                    end else if (end_hit) begin
                        state_d = ST_END;
                    end
                end
                ST_END:  state_d = ST_END;
                ST_ESC:  state_d = ST_ESC;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_valid <= 1'b0;
            done       <= 1'b0;
            escape     <= 1'b0;
        end else begin
            step_valid <= advance;
            if (init) begin
                done   <= max_zero;
                escape <= 1'b0;
            end else begin
                if (esc_hit) begin
                    escape <= 1'b1;
                end
                if (end_hit) begin
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_step,
    input  logic          cfg_down,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic [CW-1:0] cfg_max,
    input  logic          step_en,
    output logic [AW-1:0] addr,
    output logic          step_valid,
    output logic          done,
    output logic          escape
);

    logic [AW-1:0] step_q;
    logic          down_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic [CW-1:0] max_q;
    logic          advance;
    logic          nxt_in_win;
    logic          last_step;
    logic          max_zero;

    assign max_zero = (cfg_max == '0);

    asu_cfg_reg #(.AW(AW), .CW(CW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init),
        .in_step  (cfg_step),
        .in_down  (cfg_down),
        .in_base  (cfg_base),
        .in_limit (cfg_limit),
        .in_max   (cfg_max),
        .step_q   (step_q),
        .down_q   (down_q),
        .base_q   (base_q),
        .limit_q  (limit_q),
        .max_q    (max_q)
    );

    asu_addr_path #(.AW(AW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (init),
        .start      (cfg_start),
        .advance    (advance),
        .step       (step_q),
        .down       (down_q),
        .base       (base_q),
        .limit      (limit_q),
        .addr_q     (addr),
        .nxt_in_win (nxt_in_win)
    );

    asu_step_count #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (init),
        .advance   (advance),
        .max_q     (max_q),
        .last_step (last_step)
    );

    asu_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .max_zero   (max_zero),
        .step_en    (step_en),
        .nxt_in_win (nxt_in_win),
        .last_step  (last_step),
        .advance    (advance),
        .step_valid (step_valid),
        .done       (done),
        .escape     (escape)
    );

endmodule

// File: rtl/addr_stepper_chk.sv
module addr_stepper_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init,
    input logic          step_en,
    input logic [AW-1:0] cfg_start,
    input logic [AW-1:0] addr,
    input logic          step_valid,
    input logic          done,
    input logic          escape,
    input logic [AW-1:0] step_q,
    input logic          down_q,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] limit_q
);

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (addr == $past(cfg_start)) && !escape && !step_valid); // R2

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !$past(down_q)) |-> (addr == $past(addr) + $past(step_q))); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && $past(down_q)) |-> (addr == $past(addr) - $past(step_q))); // R4

    AST_NO_EN_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> !step_valid); // R5

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (addr >= base_q) && (addr <= limit_q)); // R8

    AST_ESC_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(escape) |-> $stable(addr) && !step_valid); // R9

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && escape)); // R10

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || escape) && !init) |=> $stable(addr) && $stable(done) && $stable(escape)); // R11

    AST_STOP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done || escape) |=> !step_valid); // R11

endmodule

bind addr_stepper addr_stepper_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init       (init),
    .step_en    (step_en),
    .cfg_start  (cfg_start),
    .addr       (addr),
    .step_valid (step_valid),
    .done       (done),
    .escape     (escape),
    .step_q     (step_q),
    .down_q     (down_q),
    .base_q     (base_q),
    .limit_q    (limit_q)
);

// File: tb/addr_stepper_bench.sv
`timescale 1ns/1ps
module addr_stepper_bench;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int HALF = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW-1:0] cfg_step = '0;
    logic          cfg_down = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic [CW-1:0] cfg_max = '0;
    logic          step_en = 1'b0;
    logic [AW-1:0] addr;
    logic          step_valid;
    logic          done;
    logic          escape;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // reference state
    logic [AW-1:0] m_addr;
    logic [AW-1:0] m_step;
    logic          m_down;
    logic [AW-1:0] m_base;
    logic [AW-1:0] m_limit;
    int            m_max;
    int            m_cnt;
    bit            m_run;
    bit            m_done;
    bit            m_esc;
    bit            m_sv;

    always #HALF clk = ~clk;

    addr_stepper #(.AW(AW), .CW(CW)) u_addr_stepper (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .cfg_start  (cfg_start),
        .cfg_step   (cfg_step),
        .cfg_down   (cfg_down),
        .cfg_base   (cfg_base),
        .cfg_limit  (cfg_limit),
        .cfg_max    (cfg_max),
        .step_en    (step_en),
        .addr       (addr),
        .step_valid (step_valid),
        .done       (done),
        .escape     (escape)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(addr == m_addr, tag, "addr", int'(addr), int'(m_addr));
        check(step_valid == m_sv, tag, "step_valid", int'(step_valid), int'(m_sv));
        check(done == m_done, tag, "done", int'(done), int'(m_done));
        check(escape == m_esc, tag, "escape", int'(escape), int'(m_esc));
    endtask

    // Runs one cycle from a negedge to the next and updates the reference.
    task automatic cycle(input bit do_init, input bit en);
        logic [AW-1:0] nxt;
        init    = do_init;
        step_en = en;
        @(negedge clk);
        init    = 1'b0;
        step_en = 1'b0;
        m_sv    = 1'b0;
        if (do_init) begin
            m_addr  = cfg_start;
            m_step  = cfg_step;
            m_down  = cfg_down;
            m_base  = cfg_base;
            m_limit = cfg_limit;
            m_max   = int'(cfg_max);
            m_cnt   = 0;
            m_esc   = 1'b0;
            m_done  = (cfg_max == 0);
            m_run   = (cfg_max != 0);
        end else if (m_run && en) begin
            nxt = m_down ? (m_addr - m_step) : (m_addr + m_step);
            if (nxt < m_base || nxt > m_limit) begin
                m_esc = 1'b1;
                m_run = 1'b0;
            end else begin
                m_addr = nxt;
                m_cnt++;
                m_sv = 1'b1;
                if (m_cnt == m_max) begin
                    m_done = 1'b1;
                    m_run  = 1'b0;
                end
            end
        end
    endtask

    task automatic setup(input int st, input int sp, input bit dn,
                         input int lo, input int hi, input int mx);
        cfg_start = AW'(st);
        cfg_step  = AW'(sp);
        cfg_down  = dn;
        cfg_base  = AW'(lo);
        cfg_limit = AW'(hi);
        cfg_max   = CW'(mx);
        cycle(1'b1, 1'b0);
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_addr = '0; m_step = '0; m_down = 0; m_base = '0; m_limit = '0;
        m_max = 0; m_cnt = 0; m_run = 0; m_done = 0; m_esc = 0; m_sv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        // R1: enable before any init does nothing
        cycle(1'b0, 1'b1);
        check_all("R1");

        // R3 R4 R6: sweep over direction, step size and count
        for (int dn = 0; dn < 2; dn++) begin
            for (int sp = 1; sp <= 4; sp++) begin
                for (int mx = 1; mx <= 4; mx++) begin
                    setup(dn ? 200 : 100, sp, dn[0], 0, 1000, mx);
                    check_all("R2");
                    for (int k = 0; k <= mx; k++) begin
                        cycle(1'b0, 1'b1);
                        check_all(dn ? "R4" : "R3");
                    end
                    check(done == 1'b1, "R6", "done after count", int'(done), 1);
                end
            end
        end

        // R5: idle cycles between steps
        setup(50, 5, 1'b0, 0, 1000, 6);
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, k[0]);
            check_all("R5");
        end

        // R7: zero count ends at once
        setup(30, 2, 1'b0, 0, 1000, 0);
        check(done == 1'b1, "R7", "done on zero count", int'(done), 1);
        cycle(1'b0, 1'b1);
        check_all("R7");

        // R8 R9: inclusive bounds then escape
        setup(10, 5, 1'b0, 10, 20, 10);
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b1);
            check_all(k < 2 ? "R8" : "R9");
        end
        check(addr == 20, "R9", "addr held at limit", int'(addr), 20);
        setup(20, 5, 1'b1, 10, 20, 10);
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b1);
            check_all(k < 2 ? "R8" : "R9");
        end

        // R9: down wrap escapes, up wrap inside full window accepted
        setup(2, 3, 1'b1, 0, 16'hFF00, 4);
        cycle(1'b0, 1'b1);
        check_all("R9");
        check(escape == 1'b1, "R9", "wrap escape", int'(escape), 1);
        setup(16'hFFFE, 4, 1'b0, 0, 16'hFFFF, 4);
        cycle(1'b0, 1'b1);
        check_all("R3");
        check(addr == 2, "R3", "wrapped addr", int'(addr), 2);

        // R10: final step also leaves window
        setup(0, 4, 1'b0, 0, 7, 2);
        cycle(1'b0, 1'b1);
        check_all("R10");
        cycle(1'b0, 1'b1);
        check_all("R10");
        check(escape == 1'b1 && done == 1'b0, "R10", "escape over end",
              int'({done, escape}), 1);

        // R11: stopped unit ignores enable
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b1);
            check_all("R11");
        end
        setup(40, 1, 1'b0, 0, 1000, 1);
        cycle(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 1'b1);
            check_all("R11");
        end

        // R2: init wins over step_en in the same cycle
        cfg_start = 16'd500; cfg_step = 16'd9; cfg_down = 1'b0;
        cfg_base = 16'd0; cfg_limit = 16'd1000; cfg_max = 8'd3;
        cycle(1'b1, 1'b1);
        check_all("R2");
        check(addr == 500, "R2", "start addr", int'(addr), 500);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule